// File: doc/BRIEF.md
# Three-Port Integer Register Bank with Hardwired Zero

This block holds the architectural integer registers of a small load/store core. It has two read ports, which return data combinationally from their index inputs, and one write port, which commits on the rising clock edge when its enable is high. Index 0 is a constant-zero register. Reads of index 0 always return zero, and writes aimed at index 0 are dropped.

When a write and a read name the same live register in the same cycle, the read returns the value being written instead of the stored one. A decode stage can therefore read an operand in the same cycle that writeback produces it. There is no reset. The contents of registers 1 and up are undefined until they are first written.

Top module: `regbank_3p`

## Requirements
- R1: Reading index 0 on either read port returns 0x00000000 at all times.
- R2: A write with the enable high and index 0 leaves every register unchanged. Index 0 still reads zero, and all other registers keep their values.
- R3: A write with the enable high and a non-zero index stores the data on the rising clock edge. The value is readable from then on, until the next write to that index.
- R4: While the write enable is low, no register changes at the clock edge.
- R5: When the write enable is high, the write index is non-zero and it equals the read-A index, read port A returns the write data in that same cycle.
- R6: The same-cycle forwarding of R5 applies to read port B.
- R7: Forwarding does not occur when the write enable is low or the write index is 0. The read port then returns the stored value, or zero for index 0.
- R8: When both read indices are equal, both read ports return identical data.
- R9: Each read port's data follows its index input combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| wr_en | input | 1 | Write enable |
| wr_idx | input | ADDR_W (5) | Write register index |
| wr_val | input | DATA_W (32) | Write data |
| rd_a_idx | input | ADDR_W (5) | Read port A index |
| rd_a_val | output | DATA_W (32) | Read port A data |
| rd_b_idx | input | ADDR_W (5) | Read port B index |
| rd_b_val | output | DATA_W (32) | Read port B data |

## Verification
The read results, the zero register and the forwarded write data are combinational. The bench therefore drives all inputs just after a falling edge and samples the outputs 1 ns later, inside the same low phase. A stored write is due from the rising edge that follows its request. The bench updates its reference model only at that edge, so each later read is compared against the committed value. For the combinational-read requirement, the bench changes a read index twice within one low phase and checks the output after each change, with no clock edge in between.

// File: rtl/regbank_3p.sv
module regbank_3p #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [ADDR_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_val,
  input  logic [ADDR_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_val
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] rows;
  logic                         wr_live;

  assign wr_live = wr_en && (wr_idx != '0);
  assign rows[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_row
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk)
      if (wr_live && wr_idx == ADDR_W'(i)) q <= wr_val;
    assign rows[i] = q;
  end

  assign rd_a_val = (wr_live && wr_idx == rd_a_idx) ? wr_val : rows[rd_a_idx];
  assign rd_b_val = (wr_live && wr_idx == rd_b_idx) ? wr_val : rows[rd_b_idx];
endmodule

// File: rtl/regbank_3p_chk.sv
module regbank_3p_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_idx,
  input logic [DATA_W-1:0] wr_val,
  input logic [ADDR_W-1:0] rd_a_idx,
  input logic [DATA_W-1:0] rd_a_val,
  input logic [ADDR_W-1:0] rd_b_idx,
  input logic [DATA_W-1:0] rd_b_val
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  a_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    rd_a_idx == '0 |-> rd_a_val == '0);

  // R1
  b_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    rd_b_idx == '0 |-> rd_b_val == '0);

  // R5
  a_fwd_chk: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && wr_idx != '0 && wr_idx == rd_a_idx) |-> rd_a_val == wr_val);

  // R6
  b_fwd_chk: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && wr_idx != '0 && wr_idx == rd_b_idx) |-> rd_b_val == wr_val);

  // R8
  same_idx_chk: assert property (@(posedge clk) disable iff (!armed)
    rd_a_idx == rd_b_idx |-> rd_a_val == rd_b_val);

  // R3
  commit_chk: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && wr_idx != '0) |=>
      (rd_a_idx != $past(wr_idx) || (wr_en && wr_idx == rd_a_idx)
       || rd_a_val == $past(wr_val)));
endmodule

bind regbank_3p regbank_3p_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/regbank_3p_tb.sv
`timescale 1ns/1ps
module regbank_3p_tb;
  logic        clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_val = '0;
  logic [4:0]  rd_a_idx = '0;
  logic [4:0]  rd_b_idx = '0;
  logic [31:0] rd_a_val, rd_b_val;

  logic [31:0] model [32];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  regbank_3p u_dut (.clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_a_idx(rd_a_idx), .rd_a_val(rd_a_val), .rd_b_idx(rd_b_idx), .rd_b_val(rd_b_val));

  always #5 clk = ~clk;

  function automatic logic [31:0] expect_rd(input logic [4:0] idx);
    if (idx == 0) return 32'h0;
    if (wr_en && wr_idx != 0 && wr_idx == idx) return wr_val;
    return model[idx];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic [4:0] wi, input logic [31:0] wv,
                      input logic [4:0] ra, input logic [4:0] rb,
                      input string ta, input string tb);
    @(negedge clk);
    wr_en = en; wr_idx = wi; wr_val = wv; rd_a_idx = ra; rd_b_idx = rb;
    #1;
    check(rd_a_val, expect_rd(ra), ta);
    check(rd_b_val, expect_rd(rb), tb);
    @(posedge clk);
    if (en && wi != 0) model[wi] = wv;
  endtask

  function automatic string auto_tag(input logic en, input logic [4:0] wi, input logic [4:0] r);
    if (r == 0) return "R1";
    if (en && wi != 0 && wi == r) return "R5";
    if (wi == r) return "R7";
    return "R3";
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model[0] = 32'h0;
    // R1: zero register before any write
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R1", "R1");
    // fill every register
    for (int i = 1; i < 32; i++) step(1'b1, 5'(i), $urandom, 5'd0, 5'd0, "R1", "R1");
    // R3: read everything back, R8 both ports same index
    for (int i = 0; i < 32; i++) step(1'b0, 5'd0, 32'h0, 5'(i), 5'(i), "R3", "R8");
    // R2, R7: write to index 0 is not forwarded and not stored
    step(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd1, "R7", "R2");
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd1, "R2", "R2");
    // R7, R4: disabled write to 5 is not forwarded and not stored
    step(1'b0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd6, "R7", "R4");
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd5, "R4", "R4");
    // R5, R6, R8: forwarding on both ports
    step(1'b1, 5'd7, 32'hA5A5_0001, 5'd7, 5'd7, "R5", "R6");
    step(1'b0, 5'd0, 32'h0, 5'd7, 5'd3, "R3", "R3");
    step(1'b1, 5'd31, 32'h8000_0000, 5'd30, 5'd31, "R3", "R6");
    step(1'b0, 5'd0, 32'h0, 5'd31, 5'd30, "R3", "R3");
    // R9: read follows index with no clock edge
    @(negedge clk);
    wr_en = 1'b0; rd_a_idx = 5'd7; rd_b_idx = 5'd31; #1;
    check(rd_a_val, model[7], "R9");
    check(rd_b_val, model[31], "R9");
    rd_a_idx = 5'd31; rd_b_idx = 5'd7; #1;
    check(rd_a_val, model[31], "R9");
    check(rd_b_val, model[7], "R9");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic en;
      logic [4:0] wi, ra, rb;
      en = 1'($urandom);
      wi = 5'($urandom);
      ra = ($urandom % 4 == 0) ? wi : 5'($urandom);
      rb = ($urandom % 4 == 0) ? ra : 5'($urandom);
      step(en, wi, $urandom, ra, rb, auto_tag(en, wi, ra),
           (en && wi != 0 && wi == rb) ? "R6" : auto_tag(en, wi, rb));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule